// File: doc/BRIEF.md
# Framed Manchester Byte Transmitter

This block sends one byte at a time as a self-contained Manchester frame on a single line that is only driven while a frame is in flight. Software writes a byte while the block is idle, then raises the enable input. The block drives the line low for a two-bit-time lead-in and sends a three-half-bit high / three-half-bit low sync shape. It then sends the eight data bits, least significant first, followed by one trailing bit coded as zero. The line is held low for a two-bit-time pause and then released. A one-cycle done pulse marks a completed frame and can feed an interrupt line.

All timing comes from a programmable half-bit divider, so one half-bit lasts `div_val + 1` clock cycles. The pad ring combines `line_out` and `line_oe` into a tri-state buffer. When `line_oe` is low the pin floats. Dropping the enable in the middle of a frame stops it at the next bit-time boundary, and no done pulse is produced.

Top module: `mfe_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_oe`, `line_out`, `busy` and `done` are all 0.
- R2: A frame starts on the first clock edge that sees `enc_en`=1 with a byte loaded. `line_oe` rises one cycle later, which is within one bit-time. The first 4 half-bits of the frame are driven low.
- R3: After the lead-in, the line is high for 3 half-bits and then low for 3 half-bits. No other part of the frame holds the line high for longer than 2 half-bits.
- R4: Data bits D0 to D7 follow in that order. A 1 is sent as low then high and a 0 as high then low, each half lasting one half-bit.
- R5: After D7 comes one trailing bit coded as 0 (high then low), then 4 half-bits of low. `line_oe` then falls, so a complete frame keeps `line_oe` high for exactly 32 half-bits.
- R6: One half-bit lasts `div_val`+1 clock cycles. `div_val` must not change while `busy` is high.
- R7: `done` is high for exactly one cycle, in the first cycle after `line_oe` falls at the end of a complete frame. It stays low when a frame is aborted.
- R8: `busy` is high in exactly the cycles in which `line_oe` is high.
- R9: A write (`wr_en`=1) is accepted only while no frame is active, and writes made during a frame are discarded. Each loaded byte is sent once: holding `enc_en` high after a frame does not resend it.
- R10: If `enc_en` is 0 at the end of an odd-numbered half-bit of the frame (half-bits counted from 0 at the start of the lead-in), the frame stops there. As a result, an aborted frame drives the line for a whole multiple of 2 half-bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | Encode enable; starts a frame when a byte is loaded, aborts on low |
| div_val | input | DIV_W | Half-bit length minus one, in clock cycles |
| wr_en | input | 1 | Load strobe for the byte register |
| wr_data | input | DATA_W | Byte to send |
| line_out | output | 1 | Serial line level |
| line_oe | output | 1 | Line drive enable; low means the pin floats |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after a complete frame |

## Verification
The embedded assertions check the following on every cycle:
- the divider's tick spacing;
- that a start always enters the first half-bit;
- that the frame never stops except at an odd half-bit boundary or after the last half-bit;
- that `done` appears only as a single cycle directly after the line is released.

The exact waveform can only be shown by the bench's scenarios. These cover the sync shape, the LSB-first bit order and coding, the frame length under different divider values, discarded writes during a frame, the single-shot behaviour under a held enable, and the abort length. The bench shows these by decoding the captured line and by comparing every cycle against its behavioural model.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = $clog2(DATA_W);
  // Frame layout in half-bit slots
  localparam int LEAD_HALVES  = 4;
  localparam int SYNC_HALVES  = 3;
  localparam int TRAIL_HALVES = 2;
  localparam int PAUSE_HALVES = 4;
  localparam int SYNC_HI_FIRST = LEAD_HALVES;
  localparam int SYNC_LO_FIRST = SYNC_HI_FIRST + SYNC_HALVES;
  localparam int DATA_FIRST    = SYNC_LO_FIRST + SYNC_HALVES;
  localparam int TRAIL_FIRST   = DATA_FIRST + 2 * DATA_W;
  localparam int PAUSE_FIRST   = TRAIL_FIRST + TRAIL_HALVES;
  localparam int SLOTS         = PAUSE_FIRST + PAUSE_HALVES;
  localparam int SLOT_W        = $clog2(SLOTS);
  localparam int LAST_SLOT     = SLOTS - 1;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Line level for a given half-bit slot of the frame
  function automatic logic slot_level(input slot_t s, input byte_t d);
    int o;
    logic [IDX_W-1:0] bi;
    if (int'(s) < SYNC_HI_FIRST)      return 1'b0;
    else if (int'(s) < SYNC_LO_FIRST) return 1'b1;
    else if (int'(s) < DATA_FIRST)    return 1'b0;
    else if (int'(s) < TRAIL_FIRST) begin
      o  = int'(s) - DATA_FIRST;
      bi = IDX_W'(o >> 1);
      // second half carries the bit value, first half its inverse
      return (o % 2 == 1) ? d[bi] : ~d[bi];
    end
    else if (int'(s) == TRAIL_FIRST)  return 1'b1;
    else                               return 1'b0;
  endfunction
endpackage

// File: rtl/mfe_rate_div.sv
module mfe_rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (cnt == div_val) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == div_val);

  // R6: with a non-zero divisor, two ticks never come back to back
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div_val != '0) |=> (!tick || !$stable(div_val)));
endmodule

// File: rtl/mfe_frame_seq.sv
module mfe_frame_seq
  import mfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  enc_en,
  input  logic  loaded,
  input  logic  tick,
  output logic  start,
  output logic  active,
  output slot_t slot,
  output logic  done_evt
);
  logic at_last;
  logic at_bit_edge;

  assign start       = !active && enc_en && loaded;
  assign at_last     = tick && (slot == slot_t'(LAST_SLOT));
  assign at_bit_edge = tick && slot[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      slot     <= '0;
      done_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      if (start) begin
        active <= 1'b1;
        slot   <= '0;
      end else if (active && tick) begin
        if (at_last) begin
          active   <= 1'b0;
          done_evt <= 1'b1;
        end else if (at_bit_edge && !enc_en) begin
          active <= 1'b0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  // R2: a start always enters the lead-in at slot 0
  a_r2_start_slot0: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && slot == '0));
  // R10: without a bit boundary the frame keeps running
  a_r10_no_midbit_stop: assert property (@(posedge clk) disable iff (rst)
    (active && !at_bit_edge) |=> active);
  // R10: an abort at a boundary stops with no completion event
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    (active && at_bit_edge && !at_last && !enc_en) |=> (!active && !done_evt));
  // R5: the last slot ends the frame and flags completion
  a_r5_frame_end: assert property (@(posedge clk) disable iff (rst)
    (active && at_last) |=> (!active && done_evt));
endmodule

// File: rtl/mfe_line_drv.sv
module mfe_line_drv
  import mfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  slot_t slot,
  input  byte_t data,
  input  logic  done_evt,
  output logic  line_out,
  output logic  line_oe,
  output logic  busy,
  output logic  done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b0;
      line_oe  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      line_out <= active ? slot_level(slot, data) : 1'b0;
      line_oe  <= active;
      busy     <= active;
      done     <= done_evt;
    end
  end

  // R7: done follows directly on the release of the line
  a_r7_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (!line_oe && $past(line_oe)));
  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mfe_encoder.sv
module mfe_encoder
  import mfe_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line_out,
  output logic              line_oe,
  output logic              busy,
  output logic              done
);
  byte_t data_q;
  logic  loaded;
  logic  start;
  logic  active;
  logic  tick;
  logic  done_evt;
  slot_t slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      loaded <= 1'b0;
    end else if (start) begin
      loaded <= 1'b0;
    end else if (wr_en && !active) begin
      data_q <= wr_data;
      loaded <= 1'b1;
    end
  end

  mfe_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(start), .div_val(div_val), .tick(tick)
  );

  mfe_frame_seq u_seq (
    .clk(clk), .rst(rst), .enc_en(enc_en), .loaded(loaded), .tick(tick),
    .start(start), .active(active), .slot(slot), .done_evt(done_evt)
  );

  mfe_line_drv u_drv (
    .clk(clk), .rst(rst), .active(active), .slot(slot), .data(data_q),
    .done_evt(done_evt), .line_out(line_out), .line_oe(line_oe),
    .busy(busy), .done(done)
  );

  // R9: the byte under transmission cannot be overwritten
  a_r9_data_frozen: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(data_q));
  // R9: a started byte is consumed
  a_r9_consumed: assert property (@(posedge clk) disable iff (rst)
    start |=> !loaded);
endmodule

// File: tb/mfe_encoder_tb.sv
`timescale 1ns/1ps
module mfe_encoder_tb;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_en = 1'b0;
  logic [DIV_W-1:0] div_val = 16'd1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic line_out, line_oe, busy, done;

  always #2.5 clk = ~clk;

  mfe_encoder #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .enc_en(enc_en), .div_val(div_val),
    .wr_en(wr_en), .wr_data(wr_data), .line_out(line_out),
    .line_oe(line_oe), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected frame as 32 half-bit levels, built from the requirements
  function automatic bit [31:0] frame_bits(input bit [7:0] d);
    bit [31:0] f = '0;
    f[4] = 1; f[5] = 1; f[6] = 1;              // R3 sync high
    for (int i = 0; i < 8; i++) begin           // R4 data
      f[10 + 2*i] = !d[i];
      f[11 + 2*i] = d[i];
    end
    f[26] = 1;                                  // R5 trailing zero
    return f;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_act = 0, m_cyc = 0, m_loaded = 0, m_dq = 0;
  bit [7:0] m_data = 0;
  bit e_oe = 0, e_line = 0, e_busy = 0, e_done = 0;
  string e_tag = "R1";
  bit cmp_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_cyc = 0; m_loaded = 0; m_dq = 0; m_data = 0;
      e_oe = 0; e_line = 0; e_busy = 0; e_done = 0; e_tag = "R1";
    end else begin
      int h, s;
      bit [31:0] fb;
      h = int'(div_val) + 1;
      fb = frame_bits(m_data);
      s = m_cyc / h;
      e_oe = (m_act != 0); e_busy = e_oe; e_done = (m_dq != 0);
      e_line = e_oe ? fb[s] : 1'b0;
      if (!e_oe) e_tag = "R1";
      else if (s < 4) e_tag = "R2";
      else if (s < 10) e_tag = "R3";
      else if (s < 26) e_tag = "R4";
      else e_tag = "R5";
      if (m_act != 0) begin
        bit eos;
        eos = (m_cyc % h == h - 1);
        if (eos && s == 31) begin m_act = 0; m_dq = 1; end
        else if (eos && (s % 2 == 1) && !enc_en) begin m_act = 0; m_dq = 0; end
        else begin m_cyc++; m_dq = 0; end
      end else begin
        m_dq = 0;
        if (enc_en && m_loaded != 0) begin m_act = 1; m_cyc = 0; m_loaded = 0; end
        else if (wr_en) begin m_data = wr_data; m_loaded = 1; end
      end
    end
  end

  // ---------------- monitor and per-cycle compare ----------------
  bit cap[$];
  int oe_cnt = 0, done_cnt = 0, run = 0, max_run = 0;

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(line_oe == e_oe, {e_tag, " line_oe"}, line_oe, e_oe);
      chk(line_out == e_line, {e_tag, " line_out"}, line_out, e_line);
      chk(busy == e_busy, "R8 busy", busy, e_busy);
      chk(done == e_done, "R7 done", done, e_done);
      if (line_oe) begin
        cap.push_back(line_out);
        oe_cnt++;
        run = line_out ? run + 1 : 0;
        if (run > max_run) max_run = run;
      end else run = 0;
      if (done) done_cnt++;
    end
  end

  task automatic mon_clear();
    cap.delete(); oe_cnt = 0; done_cnt = 0; run = 0; max_run = 0;
  endtask

  task automatic load_byte(input bit [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit [7:0] decode(input int h);
    bit [7:0] r = 0;
    for (int i = 0; i < 8; i++) r[i] = cap[(11 + 2*i) * h + h/2];
    return r;
  endfunction

  task automatic send_frame(input bit [7:0] d, input int dv);
    int h, lat, lead_ok, coded_ok;
    h = dv + 1;
    div_val = DIV_W'(dv);
    load_byte(d);
    mon_clear();
    enc_en = 1'b1;
    lat = 0;
    while (!line_oe && lat < 1000) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= 2*h, "R2 start latency", lat, 2);
    while (done_cnt == 0 && lat < 5000) begin @(negedge clk); lat++; end
    enc_en = 1'b0;
    repeat (3) @(negedge clk);
    lead_ok = 1;
    for (int i = 0; i < 4*h && i < cap.size(); i++) if (cap[i]) lead_ok = 0;
    chk(lead_ok == 1, "R2 lead-in low", lead_ok, 1);
    chk(oe_cnt == 32*h, (dv == 4) ? "R6 frame length" : "R5 frame length", oe_cnt, 32*h);
    chk(max_run == 3*h, "R3 sync high run", max_run, 3*h);
    if (cap.size() >= 32*h) begin
      coded_ok = 1;
      for (int i = 0; i < 8; i++)
        if (cap[(10 + 2*i) * h + h/2] == cap[(11 + 2*i) * h + h/2]) coded_ok = 0;
      chk(coded_ok == 1, "R4 mid-bit transition", coded_ok, 1);
      chk(decode(h) == d, "R4 data LSB first", decode(h), d);
      chk(cap[26*h + h/2] == 1 && cap[27*h + h/2] == 0, "R5 trailing zero",
          cap[27*h + h/2], 0);
    end
    chk(done_cnt == 1, "R7 done count", done_cnt, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    chk(!line_oe && !line_out && !busy && !done, "R1 reset state",
        {line_oe, line_out, busy, done}, 0);

    send_frame(8'hA5, 1);
    send_frame(8'h3C, 4);
    send_frame(8'h00, 0);
    send_frame(8'hFF, 2);

    // R9: write during a frame is dropped; held enable does not resend
    div_val = 16'd1;
    load_byte(8'h81);
    mon_clear();
    enc_en = 1'b1;
    repeat (20) @(negedge clk);
    load_byte(8'h7E);
    while (done_cnt == 0) @(negedge clk);
    chk(decode(2) == 8'h81, "R9 busy write dropped", decode(2), 8'h81);
    oe_cnt = 0;
    repeat (40) @(negedge clk);
    chk(oe_cnt == 0, "R9 no resend under held enable", oe_cnt, 0);
    enc_en = 1'b0;
    @(negedge clk);
    send_frame(8'h7E, 1);

    // R10: abort mid-frame
    div_val = 16'd1;
    load_byte(8'h55);
    mon_clear();
    enc_en = 1'b1;
    while (oe_cnt < 29) @(negedge clk);
    enc_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(oe_cnt < 64 && oe_cnt > 0, "R10 abort shortens frame", oe_cnt, 32);
    chk(oe_cnt % 4 == 0, "R10 abort on bit boundary", oe_cnt % 4, 0);
    chk(done_cnt == 0, "R10 no done on abort", done_cnt, 0);
    chk(!line_oe && !busy, "R1 idle after abort", line_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule